// File: doc/BRIEF.md
# Interrupt Line Servicing and End-of-Interrupt Engine

This block holds the per-line delivery logic for a bank of interrupt input lines. It samples each line every cycle and keeps a registered copy of its level. It applies edge or level semantics according to a per-line configuration that a separate register block supplies. When a line qualifies for delivery, the block raises a one-cycle inject bit for that line. With the bit it places the line's vector, delivery mode and destination in that line's lane of the payload buses. The downstream delivery port always accepts.

Level-mode lines coalesce through a per-line "remote request pending" flag. An end-of-interrupt broadcast carries a vector. It clears the flag of every level-mode line with that vector and pulses a resample strobe back to that line's source. The broadcast also re-services every level-mode line that is still high, so the block injects again any line whose source kept it asserted. A configuration update has the same re-service effect on the updated line. One designated line, the real-time clock line, has an extra pending flag. That flag coalesces the line's deliveries whatever its trigger mode.

Top module: `irq_service_engine`

## Requirements
- R1: While rst_n is low and in the first cycle after it, inject_o, resample_o, remote_irr_o, clk_remote_irr_o and all payload buses are zero.
- R2: An edge-mode line (cfg_level_i bit = 0) that rises from 0 to 1 raises its inject_o bit for exactly one cycle, one clock after the rising sample. Holding it high and lowering it inject nothing. A later rise injects again.
- R3: A masked line (cfg_mask_i bit = 1) never injects. The line's level is still tracked. An edge-mode line that rose while masked and is unmasked while still high injects only on its next rise.
- R4: An injection on a level-mode line (cfg_level_i bit = 1) sets that line's remote_irr_o bit. While the bit is set, further rises on that line are coalesced and inject nothing.
- R5: An end-of-interrupt with vector V (eoi_valid_i = 1) clears remote_irr_o and pulses resample_o, one clock later, for each level-mode line whose vector equals V. Edge-mode lines and lines with other vectors are unaffected.
- R6: During an end-of-interrupt, every level-mode, unmasked line whose input is still high is serviced again. Such a line whose flag was cleared by that same broadcast injects in the same cycle as its resample pulse.
- R7: For line CLK_PIN (default 8), an injection in edge mode sets clk_remote_irr_o. While that flag is set, the line does not inject in either mode. An end-of-interrupt whose vector equals the line's vector clears the flag.
- R8: A configuration update (cfg_update_i bit = 1) that leaves a line in edge mode clears its remote_irr_o bit. An update that leaves a line level-mode, unmasked and high with no pending flag injects it one clock later.
- R9: Masking and then unmasking a level-mode line through updates leaves its remote_irr_o bit unchanged.
- R10: Lines qualifying in the same cycle all raise their inject_o bits together.
- R11: An end-of-interrupt and a rise on the same line in the same cycle are ordered with the end-of-interrupt first. A level-mode line with a pending flag and a matching vector therefore injects once.
- R12: Lane i of inject_vector_o (8 bits at 8*i), inject_dmode_o (3 bits at 3*i) and inject_dest_o (8 bits at 8*i) carries line i's configuration in the cycle its inject bit is high. Lanes of non-injecting lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | NUM_PINS | Interrupt input levels, 1 = asserted |
| cfg_vector_i | input | NUM_PINS*8 | Per-line vector |
| cfg_dmode_i | input | NUM_PINS*3 | Per-line delivery mode |
| cfg_dest_i | input | NUM_PINS*8 | Per-line destination |
| cfg_level_i | input | NUM_PINS | Trigger mode, 1 = level, 0 = edge |
| cfg_mask_i | input | NUM_PINS | Mask, 1 = masked |
| cfg_update_i | input | NUM_PINS | One-cycle strobe: line's configuration was just rewritten |
| eoi_valid_i | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector_i | input | 8 | Vector carried by the broadcast |
| inject_o | output | NUM_PINS | One-cycle inject pulse per line |
| inject_vector_o | output | NUM_PINS*8 | Vector lanes of injecting lines |
| inject_dmode_o | output | NUM_PINS*3 | Delivery-mode lanes of injecting lines |
| inject_dest_o | output | NUM_PINS*8 | Destination lanes of injecting lines |
| resample_o | output | NUM_PINS | One-cycle resample pulse to level sources |
| remote_irr_o | output | NUM_PINS | Per-line remote request pending flags |
| clk_remote_irr_o | output | 1 | Pending flag of the clock line |

## Verification
Every result sits one register stage from its cause. Inject bits, payload lanes, resample pulses and both kinds of pending flag change at the first clock edge that samples the rise, broadcast or update. The bench drives a stimulus just after an edge and samples all outputs two nanoseconds after the next edge. It therefore reads exactly the response to that one stimulus before changing anything. One-cycle strobes are dropped right after that sample, so a check that follows can see that the block ignored them.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;
    localparam int VEC_W   = 8;
    localparam int DMODE_W = 3;
    localparam int DEST_W  = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;
endpackage

// File: rtl/irq_eoi_match.sv
module irq_eoi_match
    import irq_svc_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                      eoi_valid_i,
    input  logic [VEC_W-1:0]          eoi_vector_i,
    input  logic [NUM_PINS*VEC_W-1:0] cfg_vector_i,
    output logic [NUM_PINS-1:0]       hit_o
);
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_cmp
        assign hit_o[g] = eoi_valid_i && (cfg_vector_i[g*VEC_W +: VEC_W] == eoi_vector_i);
    end
endmodule

// File: rtl/irq_pin_logic.sv
module irq_pin_logic
    import irq_svc_pkg::*;
#(
    parameter bit IS_CLK = 1'b0
) (
    input  logic line_now_i,
    input  logic line_prev_i,
    input  logic level_mode_i,
    input  logic mask_i,
    input  logic update_i,
    input  logic eoi_any_i,
    input  logic eoi_hit_i,
    input  logic rirr_q_i,
    input  logic clk_block_i,
    output logic inject_o,
    output logic rirr_d_o,
    output logic resample_o,
    output logic clk_set_o
);
    logic is_level;
    logic rirr_mid;
    logic svc;

    always_comb begin
        is_level   = (trig_e'(level_mode_i) == TRIG_LEVEL);
        // broadcast and update act first
        rirr_mid   = rirr_q_i & ~(eoi_hit_i & is_level) & ~(update_i & ~is_level);
        resample_o = eoi_hit_i & is_level;
        svc        = (line_now_i & ~line_prev_i)
                   | (is_level & line_now_i & (eoi_any_i | update_i));
        inject_o   = svc & ~mask_i & ~(is_level & rirr_mid) & ~clk_block_i;
        rirr_d_o   = rirr_mid | (inject_o & is_level);
        clk_set_o  = IS_CLK ? (inject_o & ~is_level) : 1'b0;
    end
endmodule

// File: rtl/irq_service_engine.sv
module irq_service_engine
    import irq_svc_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int CLK_PIN  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PINS-1:0]         line_i,
    input  logic [NUM_PINS*VEC_W-1:0]   cfg_vector_i,
    input  logic [NUM_PINS*DMODE_W-1:0] cfg_dmode_i,
    input  logic [NUM_PINS*DEST_W-1:0]  cfg_dest_i,
    input  logic [NUM_PINS-1:0]         cfg_level_i,
    input  logic [NUM_PINS-1:0]         cfg_mask_i,
    input  logic [NUM_PINS-1:0]         cfg_update_i,
    input  logic                        eoi_valid_i,
    input  logic [VEC_W-1:0]            eoi_vector_i,
    output logic [NUM_PINS-1:0]         inject_o,
    output logic [NUM_PINS*VEC_W-1:0]   inject_vector_o,
    output logic [NUM_PINS*DMODE_W-1:0] inject_dmode_o,
    output logic [NUM_PINS*DEST_W-1:0]  inject_dest_o,
    output logic [NUM_PINS-1:0]         resample_o,
    output logic [NUM_PINS-1:0]         remote_irr_o,
    output logic                        clk_remote_irr_o
);
    localparam int VBUS = NUM_PINS * VEC_W;
    localparam int MBUS = NUM_PINS * DMODE_W;
    localparam int DBUS = NUM_PINS * DEST_W;

    typedef struct packed {
        logic [NUM_PINS-1:0] level;
        logic [NUM_PINS-1:0] rirr;
        logic                clk_rirr;
        logic [NUM_PINS-1:0] inject;
        logic [NUM_PINS-1:0] resample;
        logic [VBUS-1:0]     vec;
        logic [MBUS-1:0]     dmode;
        logic [DBUS-1:0]     dest;
    } state_t;

    state_t st_q, st_d;

    logic [NUM_PINS-1:0] eoi_hit;
    logic [NUM_PINS-1:0] inj_w, rirr_w, resample_w, clk_set_w;
    logic                clk_mid;

    irq_eoi_match #(.NUM_PINS(NUM_PINS)) eoi_match_i (
        .eoi_valid_i  (eoi_valid_i),
        .eoi_vector_i (eoi_vector_i),
        .cfg_vector_i (cfg_vector_i),
        .hit_o        (eoi_hit)
    );

    assign clk_mid = st_q.clk_rirr & ~eoi_hit[CLK_PIN];

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        localparam bit IS_CLK = (g == CLK_PIN);
        irq_pin_logic #(.IS_CLK(IS_CLK)) pin_i (
            .line_now_i   (line_i[g]),
            .line_prev_i  (st_q.level[g]),
            .level_mode_i (cfg_level_i[g]),
            .mask_i       (cfg_mask_i[g]),
            .update_i     (cfg_update_i[g]),
            .eoi_any_i    (eoi_valid_i),
            .eoi_hit_i    (eoi_hit[g]),
            .rirr_q_i     (st_q.rirr[g]),
            .clk_block_i  (IS_CLK ? clk_mid : 1'b0),
            .inject_o     (inj_w[g]),
            .rirr_d_o     (rirr_w[g]),
            .resample_o   (resample_w[g]),
            .clk_set_o    (clk_set_w[g])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.level    = line_i;
        st_d.rirr     = rirr_w;
        st_d.clk_rirr = clk_mid | clk_set_w[CLK_PIN];
        st_d.inject   = inj_w;
        st_d.resample = resample_w;
        for (int i = 0; i < NUM_PINS; i++) begin
            st_d.vec[i*VEC_W +: VEC_W]       = inj_w[i] ? cfg_vector_i[i*VEC_W +: VEC_W]     : '0;
            st_d.dmode[i*DMODE_W +: DMODE_W] = inj_w[i] ? cfg_dmode_i[i*DMODE_W +: DMODE_W]  : '0;
            st_d.dest[i*DEST_W +: DEST_W]    = inj_w[i] ? cfg_dest_i[i*DEST_W +: DEST_W]     : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign inject_o         = st_q.inject;
    assign inject_vector_o  = st_q.vec;
    assign inject_dmode_o   = st_q.dmode;
    assign inject_dest_o    = st_q.dest;
    assign resample_o       = st_q.resample;
    assign remote_irr_o     = st_q.rirr;
    assign clk_remote_irr_o = st_q.clk_rirr;
endmodule

// File: rtl/irq_service_chk.sv
module irq_service_chk
    import irq_svc_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int CLK_PIN  = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_PINS-1:0]         line_i,
    input logic [NUM_PINS-1:0]         cfg_level_i,
    input logic [NUM_PINS-1:0]         cfg_mask_i,
    input logic [NUM_PINS-1:0]         cfg_update_i,
    input logic                        eoi_valid_i,
    input logic [NUM_PINS-1:0]         inject_o,
    input logic [NUM_PINS-1:0]         resample_o,
    input logic [NUM_PINS-1:0]         remote_irr_o,
    input logic                        clk_remote_irr_o
);
    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((inject_o & $past(cfg_mask_i)) == '0));

    assert_edge_needs_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((inject_o & ~$past(cfg_level_i) & ~($past(line_i) & ~$past(line_i, 2))) == '0));

    assert_level_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((inject_o & $past(cfg_level_i) & ~remote_irr_o) == '0));

    assert_flag_clear_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~remote_irr_o & $past(remote_irr_o)) != '0) |-> $past(eoi_valid_i || (|cfg_update_i)));

    assert_resample_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|resample_o) |-> $past(eoi_valid_i));

    assert_clk_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_remote_irr_o) |-> inject_o[CLK_PIN]);
endmodule

bind irq_service_engine irq_service_chk #(.NUM_PINS(NUM_PINS), .CLK_PIN(CLK_PIN)) chk_i (.*);

// File: tb/irq_service_engine_tb.sv
`timescale 1ns/1ps
module irq_service_engine_tb_top;
    localparam int N  = 24;
    localparam int CP = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    line = '0;
    logic [N*8-1:0]  cfg_vec;
    logic [N*3-1:0]  cfg_dm;
    logic [N*8-1:0]  cfg_dst;
    logic [N-1:0]    cfg_level = '0;
    logic [N-1:0]    cfg_mask = '0;
    logic [N-1:0]    cfg_upd = '0;
    logic            eoi_v = 1'b0;
    logic [7:0]      eoi_vec = '0;
    logic [N-1:0]    inj, res, rirr;
    logic [N*8-1:0]  o_vec, o_dst;
    logic [N*3-1:0]  o_dm;
    logic            clk_flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_service_engine #(.NUM_PINS(N), .CLK_PIN(CP)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_i(line),
        .cfg_vector_i(cfg_vec), .cfg_dmode_i(cfg_dm), .cfg_dest_i(cfg_dst),
        .cfg_level_i(cfg_level), .cfg_mask_i(cfg_mask), .cfg_update_i(cfg_upd),
        .eoi_valid_i(eoi_v), .eoi_vector_i(eoi_vec),
        .inject_o(inj), .inject_vector_o(o_vec), .inject_dmode_o(o_dm),
        .inject_dest_o(o_dst), .resample_o(res), .remote_irr_o(rirr),
        .clk_remote_irr_o(clk_flag)
    );

    function automatic logic [7:0] vec_of(input int i);
        return 8'h30 + 8'(i);
    endfunction
    function automatic logic [7:0] dst_of(input int i);
        return 8'hC0 ^ 8'(i);
    endfunction
    function automatic logic [2:0] dm_of(input int i);
        return 3'(i % 8);
    endfunction
    function automatic logic [N*8-1:0] exp_vec(input logic [N-1:0] m);
        logic [N*8-1:0] r = '0;
        for (int i = 0; i < N; i++) if (m[i]) r[i*8 +: 8] = vec_of(i);
        return r;
    endfunction
    function automatic logic [N*8-1:0] exp_dst(input logic [N-1:0] m);
        logic [N*8-1:0] r = '0;
        for (int i = 0; i < N; i++) if (m[i]) r[i*8 +: 8] = dst_of(i);
        return r;
    endfunction
    function automatic logic [N*3-1:0] exp_dm(input logic [N-1:0] m);
        logic [N*3-1:0] r = '0;
        for (int i = 0; i < N; i++) if (m[i]) r[i*3 +: 3] = dm_of(i);
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic chk_payload(input string req, input logic [N-1:0] m);
        chk(req, "inject", 256'(inj), 256'(m));
        chk(req, "vector lanes", 256'(o_vec), 256'(exp_vec(m)));
        chk(req, "dmode lanes", 256'(o_dm), 256'(exp_dm(m)));
        chk(req, "dest lanes", 256'(o_dst), 256'(exp_dst(m)));
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            cfg_vec[i*8 +: 8] = vec_of(i);
            cfg_dst[i*8 +: 8] = dst_of(i);
            cfg_dm[i*3 +: 3]  = dm_of(i);
        end
        // R1 reset state
        tick; tick;
        chk_payload("R1", '0);
        chk("R1", "resample", 256'(res), 256'(0));
        chk("R1", "rirr", 256'(rirr), 256'(0));
        chk("R1", "clk flag", 256'(clk_flag), 256'(0));
        rst_n = 1'b1;
        tick;
        chk_payload("R1", '0);

        // R2 / R12 sweep over every edge line
        for (int i = 0; i < N; i++) begin
            if (i == CP) continue;
            line[i] = 1'b1; tick;
            chk_payload("R12", N'(1) << i);
            tick;
            chk("R2", "held high", 256'(inj), 256'(0));
            line[i] = 1'b0; tick;
            chk("R2", "fall", 256'(inj), 256'(0));
        end
        line[3] = 1'b1; tick;
        chk("R2", "second rise", 256'(inj), 256'(N'(1) << 3));
        line[3] = 1'b0; tick;

        // R3 masked edge line
        cfg_mask[5] = 1'b1; line[5] = 1'b1; tick;
        chk("R3", "masked rise", 256'(inj), 256'(0));
        cfg_mask[5] = 1'b0; cfg_upd[5] = 1'b1; tick;
        chk("R3", "unmask while high", 256'(inj), 256'(0));
        cfg_upd = '0; line[5] = 1'b0; tick;
        line[5] = 1'b1; tick;
        chk("R3", "rise after unmask", 256'(inj), 256'(N'(1) << 5));
        line[5] = 1'b0; tick;

        // R4 level line 23
        cfg_level[23] = 1'b1; cfg_upd[23] = 1'b1; tick;
        cfg_upd = '0;
        line[23] = 1'b1; tick;
        chk("R4", "level inject", 256'(inj), 256'(N'(1) << 23));
        chk("R4", "flag set", 256'(rirr), 256'(N'(1) << 23));
        line[23] = 1'b0; tick;
        line[23] = 1'b1; tick;
        chk("R4", "coalesced", 256'(inj), 256'(0));

        // R5 / R6 broadcasts
        eoi_v = 1'b1; eoi_vec = vec_of(4); tick;
        eoi_v = 1'b0;
        chk("R5", "edge vector no resample", 256'(res), 256'(0));
        chk("R5", "other vector keeps flag", 256'(rirr), 256'(N'(1) << 23));
        chk("R6", "blocked no inject", 256'(inj), 256'(0));
        eoi_v = 1'b1; eoi_vec = vec_of(23); tick;
        eoi_v = 1'b0;
        chk("R5", "resample", 256'(res), 256'(N'(1) << 23));
        chk("R6", "reinject while high", 256'(inj), 256'(N'(1) << 23));
        chk("R6", "flag set again", 256'(rirr), 256'(N'(1) << 23));
        line[23] = 1'b0; tick;
        eoi_v = 1'b1; tick;
        eoi_v = 1'b0;
        chk("R5", "resample low line", 256'(res), 256'(N'(1) << 23));
        chk("R5", "no inject when low", 256'(inj), 256'(0));
        chk("R5", "flag cleared", 256'(rirr), 256'(0));
        line[23] = 1'b1; tick;
        chk("R5", "inject after clear", 256'(inj), 256'(N'(1) << 23));

        // R9 mask round trip keeps the flag
        cfg_mask[23] = 1'b1; cfg_upd[23] = 1'b1; tick;
        chk("R9", "masked flag", 256'(rirr), 256'(N'(1) << 23));
        cfg_mask[23] = 1'b0; tick;
        cfg_upd = '0;
        chk("R9", "unmasked flag", 256'(rirr), 256'(N'(1) << 23));
        chk("R9", "no inject", 256'(inj), 256'(0));

        // R8 update re-service and level to edge
        cfg_level[22] = 1'b1; cfg_mask[22] = 1'b1; cfg_upd[22] = 1'b1; tick;
        cfg_upd = '0;
        line[22] = 1'b1; tick;
        chk("R8", "masked level", 256'(inj), 256'(0));
        cfg_mask[22] = 1'b0; cfg_upd[22] = 1'b1; tick;
        cfg_upd = '0;
        chk("R8", "update reinject", 256'(inj), 256'(N'(1) << 22));
        chk("R8", "flags", 256'(rirr), 256'((N'(1) << 22) | (N'(1) << 23)));
        cfg_level[22] = 1'b0; cfg_upd[22] = 1'b1; tick;
        cfg_upd = '0;
        chk("R8", "edge clears flag", 256'(rirr), 256'(N'(1) << 23));
        chk("R8", "edge no inject", 256'(inj), 256'(0));
        line = '0; tick;

        // R7 clock line
        line[CP] = 1'b1; tick;
        chk("R7", "first inject", 256'(inj), 256'(N'(1) << CP));
        chk("R7", "flag set", 256'(clk_flag), 256'(1));
        line[CP] = 1'b0; tick;
        line[CP] = 1'b1; tick;
        chk("R7", "coalesced", 256'(inj), 256'(0));
        eoi_v = 1'b1; eoi_vec = vec_of(CP); tick;
        eoi_v = 1'b0;
        chk("R7", "flag cleared", 256'(clk_flag), 256'(0));
        chk("R7", "no resample in edge", 256'(res), 256'(0));
        chk("R7", "no inject on broadcast", 256'(inj), 256'(0));
        line[CP] = 1'b0; tick;
        line[CP] = 1'b1; tick;
        chk("R7", "inject after clear", 256'(inj), 256'(N'(1) << CP));
        eoi_v = 1'b1; tick;
        eoi_v = 1'b0;
        line = '0; tick;

        // R10 simultaneous lines
        line = (N'(1) << 0) | (N'(1) << 7) | (N'(1) << 15); tick;
        chk_payload("R10", (N'(1) << 0) | (N'(1) << 7) | (N'(1) << 15));
        line = '0; tick;

        // R11 broadcast and rise in one cycle
        cfg_level[20] = 1'b1; cfg_upd[20] = 1'b1; tick;
        cfg_upd = '0;
        line[20] = 1'b1; tick;
        chk("R11", "first inject", 256'(inj), 256'(N'(1) << 20));
        line[20] = 1'b0; tick;
        line[20] = 1'b1; eoi_v = 1'b1; eoi_vec = vec_of(20); tick;
        eoi_v = 1'b0;
        chk("R11", "single inject", 256'(inj), 256'(N'(1) << 20));
        chk("R11", "resample", 256'(res), 256'(N'(1) << 20));
        chk("R11", "flags", 256'(rirr), 256'((N'(1) << 20) | (N'(1) << 23)));
        tick;
        chk("R11", "no repeat", 256'(inj), 256'(0));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule